// File: doc/BRIEF.md
# Fractional-Second Clock Timer

This block is an 8-bit tick counter driven by a low-speed 32.768 kHz clock-enable pulse. A prescaler turns every 128 enable pulses into one count step, so the byte advances 256 times per second. The count therefore wraps once per second, and each of its bits toggles at a fixed binary fraction of a second. Software starts, stops and zeroes the counter and reads it back through a small register port.

The timer also raises four periodic interrupt requests at 1, 2, 8 and 32 Hz. Each request is taken from the moment one chosen count bit drops from 1 to 0 as the counter steps. No separate dividers are used. Each request has a sticky pending flag, which software clears by writing a one, and an enable bit. One shared 2-bit priority level is passed to an external interrupt controller. The combined request line is asserted only when that level is nonzero.

Registers (2-bit address, 8-bit data):
- Address 0 is control. Bit 0 is the run state. Writing 1 to bit 1 zeroes the counter.
- Address 1 is the read-only count.
- Address 2 is configuration. Bits 3:0 are the request enables and bits 5:4 are the priority.
- Address 3 holds the pending flags in bits 3:0, and is written with ones to clear them.

Flag bit 0 is the 1 Hz request, bit 1 the 2 Hz, bit 2 the 8 Hz and bit 3 the 32 Hz.

Top module: `frac_tick_timer`

## Requirements
- R1: While running, the count steps by one, modulo 256, on every 128th `tick_en` pulse. It is unchanged in all other cycles.
- R2: Control bit 0 sets the run state and reads back at address 0 bit 0. While it is 0, neither the count nor the prescaler moves, even if `tick_en` pulses.
- R3: Writing 1 to control bit 1 sets the count and the prescaler to zero in the next cycle. This bit always reads as 0, and the clear never sets any flag.
- R4: A count step that takes count bit 7 from 1 to 0 sets flag bit 0. Bit 6 likewise sets flag bit 1, bit 4 sets flag bit 2, and bit 2 sets flag bit 3. A flag rises at no other time.
- R5: A flag is set by its event whatever the state of its enable bit.
- R6: Writing address 3 clears each flag whose data bit is 1 and leaves the other flags unchanged.
- R7: When a flag's event and a clear write for that flag fall in the same cycle, the flag ends up set.
- R8: Address 2 bits 3:0 (enables) and bits 5:4 (priority) read back as last written.
- R9: `irq_prio` equals the priority field. `irq_req` is 1 exactly when the priority is nonzero and some flag is set with its enable set.
- R10: After reset, the run state, count, prescaler, enables, priority and flags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse at 32.768 kHz |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| irq_req | output | 1 | Combined interrupt request |
| irq_prio | output | 2 | Priority level for the interrupt controller |

## Verification
The counter is driven in three ways:
- With `tick_en` high every cycle, exact step positions can be counted. This separates an off-by-one prescaler from a correct one.
- With a one-in-three pulse pattern, the test shows that the count follows enable pulses rather than clock cycles.
- With pulses arriving while the run state is off, the test shows that they are ignored.

A full 256-step wrap raises all four requests, which checks every tap position at once. A clear issued while low count bits are set shows that a clear creates no falling edge that sets a flag. A flag-clear write timed to the exact cycle of the first 32 Hz event checks the set-over-clear priority.

// File: rtl/ftt_pkg.sv
`timescale 1ns/1ps
package ftt_pkg;
  localparam int NUM_TAPS = 4;
  // count bit watched by each request: 1 Hz, 2 Hz, 8 Hz, 32 Hz
  localparam int TAP_POS [NUM_TAPS] = '{7, 6, 4, 2};
  localparam int PRIO_W = 2;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_CFG   = 2'd2,
    REG_FLAGS = 2'd3
  } reg_sel_e;

  // bit 'pos' drops on an increment exactly when bits pos..0 are all ones
  function automatic logic bit_drops_on_step(input logic [31:0] value, input int pos);
    logic [31:0] mask;
    mask = (32'd1 << (pos + 1)) - 32'd1;
    return (value & mask) == mask;
  endfunction

  // prescaler wrap test shared by the datapath
  function automatic logic pre_at_end(input logic [31:0] pre, input int div);
    return pre == 32'(div - 1);
  endfunction
endpackage

// File: rtl/ftt_prescaler.sv
`timescale 1ns/1ps
module ftt_prescaler #(
  parameter int PRE_DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic run,
  input  logic clear,
  output logic step
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic [PW-1:0] pre_q;
  logic          at_end;

  assign at_end = ftt_pkg::pre_at_end(32'(pre_q), PRE_DIV);
  assign step   = run && tick_en && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (clear) begin
      pre_q <= '0;
    end else if (run && tick_en) begin
      pre_q <= at_end ? '0 : pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/ftt_counter.sv
`timescale 1ns/1ps
module ftt_counter #(
  parameter int CNT_W    = 8,
  parameter int NUM_TAPS = ftt_pkg::NUM_TAPS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                clear,
  output logic [CNT_W-1:0]    cnt,
  output logic [NUM_TAPS-1:0] tap_evt
);
  logic live_step;

  // a clear overrides a step, so it can never produce a tap event
  assign live_step = step && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (live_step) begin
      cnt <= cnt + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    assign tap_evt[i] = live_step &&
                        ftt_pkg::bit_drops_on_step(32'(cnt), ftt_pkg::TAP_POS[i]);
  end
endmodule

// File: rtl/ftt_flags.sv
`timescale 1ns/1ps
module ftt_flags #(
  parameter int NUM_TAPS = ftt_pkg::NUM_TAPS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TAPS-1:0] set_evt,
  input  logic [NUM_TAPS-1:0] clr_mask,
  output logic [NUM_TAPS-1:0] flags
);
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags[i] <= 1'b0;
      end else if (set_evt[i]) begin
        flags[i] <= 1'b1;
      end else if (clr_mask[i]) begin
        flags[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/frac_tick_timer.sv
`timescale 1ns/1ps
module frac_tick_timer #(
  parameter int CNT_W   = 8,
  parameter int PRE_DIV = 128,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_req,
  output logic [1:0]        irq_prio
);
  import ftt_pkg::*;
  localparam int NT = NUM_TAPS;

  logic [CNT_W-1:0]  cnt_q;
  logic [NT-1:0]     tap_evt;
  logic [NT-1:0]     flag_q;
  logic [NT-1:0]     en_q;
  logic [PRIO_W-1:0] prio_q;
  logic              run_q;
  logic              step;
  logic              clr_cmd;
  logic              wr_ctrl, wr_cfg, wr_flags;
  logic [NT-1:0]     clr_mask;
  reg_sel_e          sel;

  assign sel      = reg_sel_e'(bus_addr);
  assign wr_ctrl  = bus_wr && (sel == REG_CTRL);
  assign wr_cfg   = bus_wr && (sel == REG_CFG);
  assign wr_flags = bus_wr && (sel == REG_FLAGS);
  assign clr_cmd  = wr_ctrl && bus_wdata[1];
  assign clr_mask = wr_flags ? bus_wdata[NT-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      en_q   <= '0;
      prio_q <= '0;
    end else begin
      if (wr_ctrl) run_q <= bus_wdata[0];
      if (wr_cfg) begin
        en_q   <= bus_wdata[NT-1:0];
        prio_q <= bus_wdata[NT+PRIO_W-1:NT];
      end
    end
  end

  ftt_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .run(run_q), .clear(clr_cmd), .step(step)
  );

  ftt_counter #(.CNT_W(CNT_W), .NUM_TAPS(NT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .clear(clr_cmd),
    .cnt(cnt_q), .tap_evt(tap_evt)
  );

  ftt_flags #(.NUM_TAPS(NT)) u_flg (
    .clk(clk), .rst_n(rst_n), .set_evt(tap_evt),
    .clr_mask(clr_mask), .flags(flag_q)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      REG_CTRL:  bus_rdata[0] = run_q;
      REG_COUNT: bus_rdata[CNT_W-1:0] = cnt_q;
      REG_CFG: begin
        bus_rdata[NT-1:0]           = en_q;
        bus_rdata[NT+PRIO_W-1:NT]   = prio_q;
      end
      REG_FLAGS: bus_rdata[NT-1:0]  = flag_q;
    endcase
  end

  assign irq_prio = prio_q;
  assign irq_req  = (prio_q != '0) && ((flag_q & en_q) != '0);
endmodule

// File: rtl/ftt_checker.sv
`timescale 1ns/1ps
module ftt_checker #(
  parameter int CNT_W    = 8,
  parameter int NUM_TAPS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [CNT_W-1:0]    cnt,
  input logic                run_q,
  input logic                clr_cmd,
  input logic [NUM_TAPS-1:0] tap_evt,
  input logic [NUM_TAPS-1:0] flags,
  input logic                irq_req,
  input logic [1:0]          irq_prio
);
  assert_step_by_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_cmd |=> (cnt == $past(cnt)) || (cnt == CNT_W'($past(cnt) + 1'b1)));

  assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !clr_cmd) |=> $stable(cnt));

  assert_clear_zeroes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> (cnt == '0) && ((flags & ~$past(flags)) == '0));

  assert_flag_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_evt == '0) |=> ((flags & ~$past(flags)) == '0));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_evt != '0) |=> ((flags & $past(tap_evt)) == $past(tap_evt)));

  assert_masked_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_prio == 2'd0) |-> !irq_req);
endmodule

bind frac_tick_timer ftt_checker #(.CNT_W(CNT_W), .NUM_TAPS(ftt_pkg::NUM_TAPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .run_q(run_q), .clr_cmd(clr_cmd),
  .tap_evt(tap_evt), .flags(flag_q), .irq_req(irq_req), .irq_prio(irq_prio)
);

// File: tb/sim_frac_tick_timer.sv
`timescale 1ns/1ps
module sim_frac_tick_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq_req;
  logic [1:0] irq_prio;

  int n_checks = 0;
  int n_fails  = 0;
  int pulse_mode = 0;   // 0 off, 1 every cycle, 2 one in three
  bit done = 1'b0;

  // reference model state
  int m_run = 0, m_pre = 0, m_cnt = 0, m_flags = 0, m_en = 0, m_prio = 0;
  int taps [4] = '{7, 6, 4, 2};

  always #2 clk = ~clk;

  frac_tick_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_prio(irq_prio)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_pre = 0; m_cnt = 0; m_flags = 0; m_en = 0; m_prio = 0;
    end else begin
      int old_cnt, set_bits, wipe;
      bit adv, clr;
      set_bits = 0;
      clr = bus_wr && bus_addr == 2'd0 && bus_wdata[1];
      adv = (m_run != 0) && tick_en && (m_pre == 127);
      if (clr) begin
        m_cnt = 0; m_pre = 0;
      end else begin
        if (m_run != 0 && tick_en) m_pre = (m_pre + 1) % 128;
        if (adv) begin
          old_cnt = m_cnt;
          m_cnt = (m_cnt + 1) % 256;
          for (int i = 0; i < 4; i++)
            if (((old_cnt >> taps[i]) & 1) == 1 && ((m_cnt >> taps[i]) & 1) == 0)
              set_bits |= (1 << i);
        end
      end
      wipe = (bus_wr && bus_addr == 2'd3) ? int'(bus_wdata[3:0]) : 0;
      m_flags = (m_flags & ~wipe) | set_bits;
      if (bus_wr && bus_addr == 2'd0) m_run = int'(bus_wdata[0]);
      if (bus_wr && bus_addr == 2'd2) begin
        m_en = int'(bus_wdata[3:0]);
        m_prio = int'(bus_wdata[5:4]);
      end
    end
  end

  function automatic int model_rdata(input int a);
    case (a)
      0: return m_run;
      1: return m_cnt;
      2: return (m_prio << 4) | m_en;
      default: return m_flags;
    endcase
  endfunction

  // every-clock comparison against the model (R1 R2 R4 R8 R9)
  always @(negedge clk) begin
    if (!done) begin
      int exp_irq;
      exp_irq = (m_prio != 0 && (m_flags & m_en) != 0) ? 1 : 0;
      n_checks++;
      if (int'(bus_rdata) != model_rdata(int'(bus_addr)) || int'(irq_req) != exp_irq ||
          int'(irq_prio) != m_prio) begin
        n_fails++;
        $display("FAIL model R1/R4/R9 addr=%0d rdata=%0h exp=%0h irq=%0d exp=%0d prio=%0d exp=%0d",
                 bus_addr, bus_rdata, model_rdata(int'(bus_addr)), irq_req, exp_irq,
                 irq_prio, m_prio);
      end
    end
  end

  // enable pulse generator
  initial begin
    int ph = 0;
    forever begin
      @(posedge clk); #1;
      ph = (ph + 1) % 3;
      tick_en = (pulse_mode == 1) || (pulse_mode == 2 && ph == 0);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_write(input int a, input int d);
    bus_wr = 1'b1; bus_addr = 2'(a); bus_wdata = 8'(d);
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input int a, input int exp);
    bus_addr = 2'(a);
    @(negedge clk);
    n_checks++;
    if (int'(bus_rdata) != exp) begin
      n_fails++;
      $display("FAIL %s addr=%0d actual=%0h expected=%0h", tag, a, bus_rdata, exp);
    end
    @(posedge clk); #1;
  endtask

  task automatic sig_chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #800000;
    n_fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    // R10 reset state
    rd_chk("R10 ctrl", 0, 0);
    rd_chk("R10 count", 1, 0);
    rd_chk("R10 cfg", 2, 0);
    rd_chk("R10 flags", 3, 0);
    sig_chk("R10 irq_req", int'(irq_req), 0);

    // R8 configuration readback
    do_write(2, 8'h2F);
    rd_chk("R8 cfg", 2, 8'h2F);
    sig_chk("R9 irq_prio", int'(irq_prio), 2);
    sig_chk("R9 no flags no req", int'(irq_req), 0);

    // R1 exact step position with a pulse every cycle
    pulse_mode = 1;
    do_write(0, 3);
    rd_chk("R3 clear bit reads 0", 0, 1);
    wait_cyc(255);
    rd_chk("R1 count after 256 pulses", 1, 2);

    // R2 stopped: pulses ignored
    do_write(0, 0);
    rd_chk("R2 run readback", 0, 0);
    pulse_mode = 2;
    wait_cyc(900);
    rd_chk("R2 count held", 1, 2);
    do_write(0, 1);
    wait_cyc(3000);
    rd_chk("R1 sparse pulses", 1, m_cnt);

    // R3 clear while low count bits set creates no flag
    pulse_mode = 0;
    do_write(3, 8'h0F);
    do_write(0, 1);
    rd_chk("R3 pre-clear flags", 3, 0);
    do_write(0, 3);
    rd_chk("R3 count zero", 1, 0);
    rd_chk("R3 no flag from clear", 3, 0);

    // R4 full wrap: all four requests
    pulse_mode = 1;
    wait_cyc(32768 + 20);
    rd_chk("R4 all taps after wrap", 3, 8'h0F);
    sig_chk("R9 request raised", int'(irq_req), 1);

    // R6 partial clear
    pulse_mode = 0;
    do_write(3, 8'h05);
    rd_chk("R6 partial clear", 3, 8'h0A);
    do_write(3, 8'h00);
    rd_chk("R6 zero write no effect", 3, 8'h0A);

    // R9 priority zero masks
    do_write(2, 8'h0F);
    sig_chk("R9 masked by prio 0", int'(irq_req), 0);
    do_write(2, 8'h31);
    sig_chk("R9 enable excludes pending", int'(irq_req), 0);

    // R5 flag set while disabled
    do_write(3, 8'h0F);
    do_write(2, 8'h30);
    pulse_mode = 1;
    do_write(0, 3);
    wait_cyc(1100);
    rd_chk("R5 flag set while disabled", 3, 8'h08);
    sig_chk("R5 no request while disabled", int'(irq_req), 0);

    // R7 clear on the same edge as the first 32 Hz event
    do_write(0, 3);
    do_write(3, 8'h0F);
    wait_cyc(1022);
    do_write(3, 8'h08);
    pulse_mode = 0;
    rd_chk("R7 set wins", 3, 8'h08);

    wait_cyc(4);
    finish_run();
  end
endmodule